// File: doc/BRIEF.md
# Dot-Clock Panel Sync Timing Generator

This block produces the raster timing for a small RGB panel driven by a dot clock: active-low horizontal and vertical sync, a data-enable strobe, and the pixel coordinates inside the visible window. Two counters, one for the position within a line and one for the line within a frame, step once for every cycle in which the dot-clock enable is high. The back porch of each line is counted at three dot clocks per porch unit, which suits panels that take one pixel as three serial colour transfers.

A run request starts the raster from count 0 of line 0. A stop request is held until the frame in progress has been fully scanned, so the panel never sees a truncated frame. A one-cycle frame-start pulse marks the first dot of every frame. With the default parameters a line is 340 dot clocks long and a frame is 249 lines long, with a 320 by 240 visible window.

Top module: `dot_sync_gen`

## Requirements
- R1: With default parameters a line lasts 340 dot counts (3 sync, 12 back porch from 3 x 4, 320 active, 5 front porch) and a frame lasts 249 lines (2 sync, 5 back porch, 240 active, 2 front porch), so one frame holds 76800 enable cycles and lasts 84660 counts.
- R2: While running, `hsync_n` is low exactly at horizontal counts 0 to H_SYNC-1 of every line and high elsewhere.
- R3: While running, `vsync_n` is low for every count of lines 0 to V_SYNC-1 and high elsewhere.
- R4: `de` is high only when the horizontal count lies in [H_WAIT, H_WAIT+H_ACTIVE) and the line lies in [V_WAIT, V_WAIT+V_ACTIVE), where H_WAIT = H_SYNC + 3*H_BP and V_WAIT = V_SYNC + V_BP.
- R5: While `de` is high, `pix_x` and `pix_y` give the offset of the current count and line from the start of the visible window; when `de` is low both are 0.
- R6: `frame_start` is high for one cycle, in the cycle where the block is running at count 0 of line 0 and `pix_en` is high.
- R7: The counters advance only in cycles where `pix_en` is high; with `pix_en` low every output holds its value except `frame_start`, which is low.
- R8: A `run_req` seen while stopped sets `running` on the next edge with the raster at count 0 of line 0; a `run_req` while running has no effect on the raster.
- R9: A `stop_req` while running is remembered and clears `running` on the edge that completes the last count of the last line of the current frame; a `stop_req` while stopped has no effect, and the next run then continues past its first frame.
- R10: After reset and whenever stopped, `running`, `de`, `frame_start`, `pix_x` and `pix_y` are 0 and both sync outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Dot-clock enable; one count per high cycle |
| run_req | input | 1 | Start scanning from count 0 of line 0 |
| stop_req | input | 1 | Stop once the current frame is complete |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high inside the visible window |
| pix_x | output | $clog2(H_ACTIVE) | Column inside the visible window |
| pix_y | output | $clog2(V_ACTIVE) | Row inside the visible window |
| frame_start | output | 1 | One-cycle pulse at the first dot of a frame |
| running | output | 1 | High while the raster is being scanned |

## Verification
Every output is decoded without further registers from the two counters and the run flag, so a `run_req` or an enabled count sampled on one edge shows on the outputs right after that edge, and a pending stop drops `running` right after the edge that ends the frame; `frame_start` also follows `pix_en` within the same cycle. The bench's model updates its own counters on the same edge from the same inputs and compares all outputs a quarter period after every rising edge, with inputs changed only on falling edges. One instance uses a shrunken raster so that irregular enable patterns, stops on and off the frame boundary and repeated runs fit in a short run, while a second instance with default timing scans one whole frame to count its line, sync and visible cycles.

// File: rtl/dot_sync_gen.sv
module dot_sync_gen #(
  parameter int H_ACTIVE = 320,
  parameter int H_SYNC   = 3,
  parameter int H_BP     = 4,
  parameter int H_FP     = 5,
  parameter int BP_MULT  = 3,
  parameter int V_ACTIVE = 240,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 5,
  parameter int V_FP     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pix_en,
  input  logic                        run_req,
  input  logic                        stop_req,
  output logic                        hsync_n,
  output logic                        vsync_n,
  output logic                        de,
  output logic [$clog2(H_ACTIVE)-1:0] pix_x,
  output logic [$clog2(V_ACTIVE)-1:0] pix_y,
  output logic                        frame_start,
  output logic                        running
);
  localparam int H_WAIT  = H_SYNC + BP_MULT * H_BP;
  localparam int H_TOTAL = H_WAIT + H_ACTIVE + H_FP;
  localparam int V_WAIT  = V_SYNC + V_BP;
  localparam int V_TOTAL = V_WAIT + V_ACTIVE + V_FP;
  localparam int HCW     = $clog2(H_TOTAL);
  localparam int VCW     = $clog2(V_TOTAL);
  localparam int XW      = $clog2(H_ACTIVE);
  localparam int YW      = $clog2(V_ACTIVE);

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           stop_pend;

  wire line_end  = hcnt == HCW'(H_TOTAL - 1);
  wire frame_end = line_end && (vcnt == VCW'(V_TOTAL - 1));
  wire step      = running && pix_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      stop_pend <= 1'b0;
      hcnt      <= '0;
      vcnt      <= '0;
    end else if (!running) begin
      if (run_req) begin
        running <= 1'b1;
        hcnt    <= '0;
        vcnt    <= '0;
      end
    end else begin
      if (step && frame_end && (stop_pend || stop_req)) begin
        running   <= 1'b0;
        stop_pend <= 1'b0;
      end else if (stop_req) begin
        stop_pend <= 1'b1;
      end
      if (step) begin
        hcnt <= line_end ? '0 : hcnt + 1'b1;
        if (line_end) vcnt <= frame_end ? '0 : vcnt + 1'b1;
      end
    end
  end

  wire h_vis = (hcnt >= HCW'(H_WAIT)) && (hcnt < HCW'(H_WAIT + H_ACTIVE));
  wire v_vis = (vcnt >= VCW'(V_WAIT)) && (vcnt < VCW'(V_WAIT + V_ACTIVE));

  assign hsync_n     = !(running && hcnt < HCW'(H_SYNC));
  assign vsync_n     = !(running && vcnt < VCW'(V_SYNC));
  assign de          = running && h_vis && v_vis;
  assign pix_x       = de ? XW'(hcnt - HCW'(H_WAIT)) : '0;
  assign pix_y       = de ? YW'(vcnt - VCW'(V_WAIT)) : '0;
  assign frame_start = step && hcnt == '0 && vcnt == '0;

  assert_fs_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pix_en) |=> running && $stable(hcnt) && $stable(vcnt));
  assert_de_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hsync_n && vsync_n);
  assert_run_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> hcnt == '0 && vcnt == '0);
  assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(hcnt) == HCW'(H_TOTAL - 1) && $past(vcnt) == VCW'(V_TOTAL - 1) && $past(pix_en));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> hsync_n && vsync_n && !de && !frame_start);
endmodule

// File: tb/sim_dot_sync_gen.sv
module sim_dot_sync_gen;
  localparam int CLKP = 10;
  localparam int HA_P [2] = '{8, 320};
  localparam int HS_P [2] = '{2, 3};
  localparam int HB_P [2] = '{1, 4};
  localparam int HF_P [2] = '{2, 5};
  localparam int VA_P [2] = '{4, 240};
  localparam int VS_P [2] = '{1, 2};
  localparam int VB_P [2] = '{2, 5};
  localparam int VF_P [2] = '{1, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pen [2];
  logic run [2];
  logic stp [2];
  logic hs_n [2];
  logic vs_n [2];
  logic de_o [2];
  logic fs_o [2];
  logic rn_o [2];
  logic [2:0] x0;
  logic [1:0] y0;
  logic [8:0] x1;
  logic [7:0] y1;

  int checks = 0, errors = 0, cyc = 0;
  int mx [2], my [2];
  bit mrun [2], mstop [2];
  int de_cnt1 = 0, hs_cnt1 = 0, run_cnt1 = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  dot_sync_gen #(.H_ACTIVE(8), .H_SYNC(2), .H_BP(1), .H_FP(2), .BP_MULT(3),
                 .V_ACTIVE(4), .V_SYNC(1), .V_BP(2), .V_FP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pen[0]), .run_req(run[0]), .stop_req(stp[0]),
    .hsync_n(hs_n[0]), .vsync_n(vs_n[0]), .de(de_o[0]), .pix_x(x0), .pix_y(y0),
    .frame_start(fs_o[0]), .running(rn_o[0]));

  dot_sync_gen u1 (
    .clk(clk), .rst_n(rst_n), .pix_en(pen[1]), .run_req(run[1]), .stop_req(stp[1]),
    .hsync_n(hs_n[1]), .vsync_n(vs_n[1]), .de(de_o[1]), .pix_x(x1), .pix_y(y1),
    .frame_start(fs_o[1]), .running(rn_o[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    for (int i = 0; i < 2; i++) begin
      int ht, vt;
      ht = HS_P[i] + 3 * HB_P[i] + HA_P[i] + HF_P[i];
      vt = VS_P[i] + VB_P[i] + VA_P[i] + VF_P[i];
      if (!rst_n) begin
        mx[i] = 0; my[i] = 0; mrun[i] = 0; mstop[i] = 0;
      end else if (!mrun[i]) begin
        if (run[i]) begin mrun[i] = 1; mx[i] = 0; my[i] = 0; end
      end else begin
        bit last;
        last = pen[i] && mx[i] == ht - 1 && my[i] == vt - 1;
        if (last && (mstop[i] || stp[i])) begin mrun[i] = 0; mstop[i] = 0; end
        else if (stp[i]) mstop[i] = 1;
        if (pen[i]) begin
          mx[i]++;
          if (mx[i] == ht) begin
            mx[i] = 0;
            my[i]++;
            if (my[i] == vt) my[i] = 0;
          end
        end
      end
    end
    #(CLKP/4);
    if (!done) begin
      for (int i = 0; i < 2; i++) begin
        int hw, vw, ex, ey, ax, ay;
        bit ehs, evs, ede, efs;
        hw = HS_P[i] + 3 * HB_P[i];
        vw = VS_P[i] + VB_P[i];
        ehs = !(mrun[i] && mx[i] < HS_P[i]);
        evs = !(mrun[i] && my[i] < VS_P[i]);
        ede = mrun[i] && mx[i] >= hw && mx[i] < hw + HA_P[i] && my[i] >= vw && my[i] < vw + VA_P[i];
        ex = ede ? mx[i] - hw : 0;
        ey = ede ? my[i] - vw : 0;
        efs = mrun[i] && mx[i] == 0 && my[i] == 0 && pen[i];
        ax = (i == 0) ? int'(x0) : int'(x1);
        ay = (i == 0) ? int'(y0) : int'(y1);
        if (!rst_n) begin
          chk(rn_o[i] == 0 && hs_n[i] && vs_n[i] && !de_o[i] && !fs_o[i] && ax == 0 && ay == 0,
              "R10 reset state", int'(rn_o[i]), 0);
        end else begin
          chk(rn_o[i] == mrun[i], "R8/R9 running", int'(rn_o[i]), int'(mrun[i]));
          chk(hs_n[i] == ehs, "R2 hsync_n", int'(hs_n[i]), int'(ehs));
          chk(vs_n[i] == evs, "R3 vsync_n", int'(vs_n[i]), int'(evs));
          chk(de_o[i] == ede, "R4 de", int'(de_o[i]), int'(ede));
          chk(ax == ex, "R5 pix_x", ax, ex);
          chk(ay == ey, "R5 pix_y", ay, ey);
          chk(fs_o[i] == efs, "R6 frame_start", int'(fs_o[i]), int'(efs));
        end
      end
      if (rst_n && rn_o[1]) run_cnt1++;
      if (rst_n && de_o[1]) de_cnt1++;
      if (rst_n && !hs_n[1]) hs_cnt1++;
    end
  end

  task automatic pulse(input int i, input bit is_run);
    @(negedge clk);
    if (is_run) run[i] = 1; else stp[i] = 1;
    @(negedge clk);
    if (is_run) run[i] = 0; else stp[i] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic small_seq();
    int ht, vt;
    ht = 2 + 3 + 8 + 2;
    vt = 1 + 2 + 4 + 1;
    idle(3);
    chk(!rn_o[0], "R10 idle before run", int'(rn_o[0]), 0);
    pen[0] = 1;
    pulse(0, 1);
    idle(300);
    pulse(0, 1);
    idle(50);
    for (int k = 0; k < 400; k++) begin @(negedge clk); pen[0] = ($urandom % 4) != 0; end
    pen[0] = 0;
    idle(20);
    chk(rn_o[0], "R7 hold with pix_en low", int'(rn_o[0]), 1);
    pen[0] = 1;
    pulse(0, 0);
    idle(ht * vt + 10);
    chk(!rn_o[0], "R9 stopped after frame", int'(rn_o[0]), 0);
    pulse(0, 0);
    idle(5);
    pulse(0, 1);
    idle(2 * ht * vt + 7);
    chk(rn_o[0], "R9 idle stop ignored", int'(rn_o[0]), 1);
    while (!(mx[0] == ht - 1 && my[0] == vt - 1)) @(negedge clk);
    stp[0] = 1;
    @(negedge clk);
    stp[0] = 0;
    chk(!rn_o[0], "R9 stop on last count", int'(rn_o[0]), 0);
    pulse(0, 1);
    for (int k = 0; k < 200; k++) begin @(negedge clk); pen[0] = ($urandom % 3) == 0; end
    pen[0] = 1;
    pulse(0, 0);
    while (rn_o[0]) @(negedge clk);
    idle(5);
  endtask

  task automatic big_seq();
    idle(3);
    pulse(1, 1);
    idle(1000);
    pulse(1, 0);
    while (rn_o[1]) @(negedge clk);
    idle(5);
  endtask

  initial begin
    pen[0] = 0; pen[1] = 1;
    run[0] = 0; run[1] = 0;
    stp[0] = 0; stp[1] = 0;
    idle(4);
    rst_n = 1;
    fork
      small_seq();
      big_seq();
    join
    chk(run_cnt1 == 84660, "R1 frame length", run_cnt1, 84660);
    chk(de_cnt1 == 76800, "R1 visible cycles", de_cnt1, 76800);
    chk(hs_cnt1 == 747, "R1 hsync low cycles", hs_cnt1, 747);
    pen[0] = 1;
    pulse(0, 1);
    idle(30);
    rst_n = 0;
    idle(3);
    chk(!rn_o[0] && !de_o[0] && hs_n[0] && vs_n[0], "R10 reset mid-run", int'(rn_o[0]), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLKP * 190000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule